// File: doc/BRIEF.md
# Two-Source Sub-Word Permute Unit

This unit assembles a destination vector of `K*32` bits from sub-words picked out of two source vectors, `v` and `w`. A 2-bit code selects the sub-word width. A 12-bit control word sets the permutation. It holds four 2-bit index fields and four source-select bits. For each of the first four destination sub-words, one index names a sub-word position and one select bit names the source. When the vector holds more than four sub-words, the same four-entry pattern repeats. Each repetition moves one position further into the source for every group of four destination sub-words.

The unit sits in the execute stage of a vector datapath. It takes operands from the register file and the control fields from the instruction. It hands the permuted vector to write-back. Widths that would leave fewer than four sub-words in a vector are rejected: the unit raises an error flag and keeps the previous result. A parameter chooses between a registered output (the default) and a purely combinational one.

Top module: `vperm_shuffle`

## Requirements
- R1: The width code selects the sub-word width W as follows: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Sub-word j occupies vector bits `[j*W+W-1 : j*W]`, so sub-word 0 is the least significant. The vector holds `VEC_W/W` sub-words.
- R2: The control fields are read in reversed bit order. Pattern entry g (0..3) takes its index n[g] from `idx_i[7-2g : 6-2g]` and its source bit s[g] from `sel_i[3-g]`.
- R3: For destination sub-words i = 0..3, r[i] equals v[n[i]] when s[i] = 0 and equals w[n[i]] when s[i] = 1.
- R4: For i >= 4, r[i] is taken from sub-word n[i mod 4] + i/4 (integer division), using the source given by s[i mod 4].
- R5: A width code is legal only when 4*W <= VEC_W. An illegal code sets `err_o` to 1 on the next cycle, and `res_o` keeps its previous value.
- R6: A legal width code clears `err_o` on the next cycle.
- R7: With OUT_REG = 1, `res_o` shows the result of the inputs present at the previous rising clock edge.
- R8: While `rst_ni` is low, `res_o` is all zeros and `err_o` is 0.
- R9: At the largest legal width (W = VEC_W/4), index field 00 01 10 11 with select 0000 copies `v` unchanged, and with select 1111 it copies `w` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_v_i | input | K*32 | First source vector (v) |
| src_w_i | input | K*32 | Second source vector (w) |
| width_sel_i | input | 2 | Sub-word width code |
| idx_i | input | 8 | Four 2-bit index fields, entry 0 in the top bits |
| sel_i | input | 4 | Four source-select bits, entry 0 in bit 3 |
| res_o | output | K*32 | Permuted vector |
| err_o | output | 1 | Illegal width reported for the previous cycle |

## Verification
Two functions can meet in the same cycle: the normal register update of the output and the hold that an illegal width forces. The bench provokes this by following a legal permute at once with an illegal width code, and by mixing illegal codes into a random stream. It judges the output against a bench model that keeps the last legal result. The repeating offset for sub-words above index three is also exercised at the 8-bit width, where sixteen sub-words give four pattern repetitions.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

   localparam int unsigned PAT_N = 4;

   function automatic int unsigned sub_width(input logic [1:0] code);
      return 8 << code;
   endfunction

   function automatic logic width_legal(input logic [1:0] code, input int unsigned vec_w);
      return (sub_width(code) * PAT_N) <= vec_w;
   endfunction

endpackage

// File: rtl/vperm_ctl_decode.sv
module vperm_ctl_decode
   import vperm_pkg::*;
#(
   parameter int unsigned VEC_W = 128
) (
   input  logic [1:0]       width_sel_i,
   input  logic [7:0]       idx_i,
   input  logic [3:0]       sel_i,
   output logic [3:0][1:0]  pat_idx_o,
   output logic [3:0]       pat_src_o,
   output logic             legal_o
);

   // reversed ordering: entry 0 sits in the most significant slot
   for (genvar g = 0; g < PAT_N; g++) begin : g_ent
      assign pat_idx_o[g] = idx_i[7-2*g -: 2];
      assign pat_src_o[g] = sel_i[3-g];
   end

   assign legal_o = width_legal(width_sel_i, VEC_W);

endmodule

// File: rtl/vperm_subword_perm.sv
module vperm_subword_perm
   import vperm_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SUB_W = 8
) (
   input  logic [VEC_W-1:0] src_v_i,
   input  logic [VEC_W-1:0] src_w_i,
   input  logic [3:0][1:0]  pat_idx_i,
   input  logic [3:0]       pat_src_i,
   output logic [VEC_W-1:0] res_o
);

   localparam int unsigned NSUB = VEC_W / SUB_W;

   if (NSUB < PAT_N) begin : g_bad
      $error("vperm_subword_perm: fewer than four sub-words");
   end

   // one destination slot per generate iteration; position = n[i%4] + i/4
   for (genvar i = 0; i < NSUB; i++) begin : g_slot
      localparam int unsigned GRP = i % PAT_N;
      localparam int unsigned OFS = i / PAT_N;
      logic [SUB_W-1:0] pick_v;
      logic [SUB_W-1:0] pick_w;
      always_comb begin
         pick_v = '0;
         pick_w = '0;
         for (int p = 0; p < PAT_N; p++) begin
            if (pat_idx_i[GRP] == p[1:0]) begin
               pick_v = src_v_i[(p + OFS)*SUB_W +: SUB_W];
               pick_w = src_w_i[(p + OFS)*SUB_W +: SUB_W];
            end
         end
      end
      assign res_o[i*SUB_W +: SUB_W] = pat_src_i[GRP] ? pick_w : pick_v;
   end

endmodule

// File: rtl/vperm_shuffle.sv
module vperm_shuffle
   import vperm_pkg::*;
#(
   parameter int unsigned K       = 4,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned VEC_W  = K * 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [VEC_W-1:0] src_v_i,
   input  logic [VEC_W-1:0] src_w_i,
   input  logic [1:0]       width_sel_i,
   input  logic [7:0]       idx_i,
   input  logic [3:0]       sel_i,
   output logic [VEC_W-1:0] res_o,
   output logic             err_o
);

   if (K < 2 || (K % 2) != 0) begin : g_k_check
      $error("vperm_shuffle: K must be even and at least 2");
   end

   logic [3:0][1:0]  pat_idx;
   logic [3:0]       pat_src;
   logic             legal;
   logic [VEC_W-1:0] cand [4];
   logic [VEC_W-1:0] perm_res;

   vperm_ctl_decode #(.VEC_W(VEC_W)) u_dec (
      .width_sel_i (width_sel_i),
      .idx_i       (idx_i),
      .sel_i       (sel_i),
      .pat_idx_o   (pat_idx),
      .pat_src_o   (pat_src),
      .legal_o     (legal)
   );

   // one permute network per width that leaves at least four sub-words
   for (genvar c = 0; c < 4; c++) begin : g_width
      localparam int unsigned SW = 8 << c;
      if (SW * PAT_N <= VEC_W) begin : g_on
         vperm_subword_perm #(.VEC_W(VEC_W), .SUB_W(SW)) u_perm (
            .src_v_i   (src_v_i),
            .src_w_i   (src_w_i),
            .pat_idx_i (pat_idx),
            .pat_src_i (pat_src),
            .res_o     (cand[c])
         );
      end else begin : g_off
         assign cand[c] = '0;
      end
   end

   assign perm_res = cand[width_sel_i];

   if (OUT_REG) begin : g_reg
      logic [VEC_W-1:0] res_q;
      logic             err_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            res_q <= '0;
            err_q <= 1'b0;
         end else begin
            err_q <= !legal;
            if (legal) res_q <= perm_res;
         end
      end
      assign res_o = res_q;
      assign err_o = err_q;
   end else begin : g_comb
      assign res_o = legal ? perm_res : '0;
      assign err_o = !legal;
   end

endmodule

// File: rtl/vperm_shuffle_chk.sv
module vperm_shuffle_chk
   import vperm_pkg::*;
#(
   parameter int unsigned VEC_W   = 128,
   parameter bit          OUT_REG = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [VEC_W-1:0] src_v_i,
   input logic [VEC_W-1:0] src_w_i,
   input logic [1:0]       width_sel_i,
   input logic [7:0]       idx_i,
   input logic [3:0]       sel_i,
   input logic [VEC_W-1:0] res_o,
   input logic             err_o
);

   function automatic logic [VEC_W-1:0] low_mask(input logic [1:0] code);
      logic [VEC_W-1:0] m;
      m = '0;
      for (int b = 0; b < VEC_W; b++) if (b < int'(sub_width(code))) m[b] = 1'b1;
      return m;
   endfunction

   logic ok_w;
   logic full_w;
   assign ok_w   = width_legal(width_sel_i, VEC_W);
   assign full_w = (sub_width(width_sel_i) * PAT_N) == VEC_W;

   if (OUT_REG) begin : g_reg_props
      // R8
      a_r8_reset_clear: assert property (@(posedge clk_i)
         $rose(rst_ni) |-> (res_o == '0 && !err_o));

      // R5
      a_r5_err_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !ok_w |=> err_o);

      // R5
      a_r5_hold_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !ok_w |=> $stable(res_o));

      // R6
      a_r6_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ok_w |=> !err_o);

      // R3, R7: entry 0 pointing at sub-word 0 of v lands in the low sub-word
      a_r3_low_subword: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ok_w && idx_i[7:6] == 2'b00 && !sel_i[3]) |=>
         (((res_o ^ $past(src_v_i)) & $past(low_mask(width_sel_i))) == '0));

      // R9
      a_r9_copy_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (full_w && idx_i == 8'h1B && sel_i == 4'h0) |=> res_o == $past(src_v_i));

      // R9
      a_r9_copy_w: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (full_w && idx_i == 8'h1B && sel_i == 4'hF) |=> res_o == $past(src_w_i));
   end

endmodule

bind vperm_shuffle vperm_shuffle_chk #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .src_v_i     (src_v_i),
   .src_w_i     (src_w_i),
   .width_sel_i (width_sel_i),
   .idx_i       (idx_i),
   .sel_i       (sel_i),
   .res_o       (res_o),
   .err_o       (err_o)
);

// File: tb/vperm_shuffle_bench.sv
module vperm_shuffle_bench;

   localparam int unsigned K  = 4;
   localparam int unsigned VW = K * 32;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic [VW-1:0] src_v_i = '0;
   logic [VW-1:0] src_w_i = '0;
   logic [1:0]    width_sel_i = '0;
   logic [7:0]    idx_i = '0;
   logic [3:0]    sel_i = '0;
   logic [VW-1:0] res_o;
   logic          err_o;

   int checks = 0;
   int fails  = 0;
   logic [VW-1:0] held = '0;
   bit done = 0;

   always #4 clk_i = ~clk_i;

   vperm_shuffle #(.K(K), .OUT_REG(1'b1)) u_vperm_shuffle (
      .clk_i(clk_i), .rst_ni(rst_ni), .src_v_i(src_v_i), .src_w_i(src_w_i),
      .width_sel_i(width_sel_i), .idx_i(idx_i), .sel_i(sel_i),
      .res_o(res_o), .err_o(err_o)
   );

   // model built from R1..R4: W = 8<<code, n[g] = idx[7-2g:6-2g], s[g] = sel[3-g]
   function automatic logic [VW-1:0] model(input logic [VW-1:0] v, input logic [VW-1:0] w,
                                           input logic [1:0] code, input logic [7:0] idx,
                                           input logic [3:0] sel);
      logic [VW-1:0] r;
      int sw, ns, g, pos;
      r  = '0;
      sw = 8 << code;
      ns = VW / sw;
      for (int i = 0; i < ns; i++) begin
         g   = i % 4;
         pos = int'(idx[7-2*g -: 2]) + i / 4;
         for (int b = 0; b < sw; b++)
            r[i*sw + b] = sel[3-g] ? w[pos*sw + b] : v[pos*sw + b];
      end
      return r;
   endfunction

   function automatic bit legal(input logic [1:0] code);
      return ((8 << code) * 4) <= VW;
   endfunction

   task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s res act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s err act=%b exp=%b", req, act, exp);
      end
   endtask

   // drive at a falling edge, check after the next rising edge (R7 latency)
   task automatic apply(input string req, input logic [VW-1:0] v, input logic [VW-1:0] w,
                        input logic [1:0] code, input logic [7:0] idx, input logic [3:0] sel);
      @(negedge clk_i);
      src_v_i = v; src_w_i = w; width_sel_i = code; idx_i = idx; sel_i = sel;
      if (legal(code)) held = model(v, w, code, idx, sel);
      @(negedge clk_i);
      check_vec(req, res_o, held);
      check_bit(req, err_o, !legal(code));
   endtask

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] x;
      for (int q = 0; q < K; q++) x[q*32 +: 32] = $urandom();
      return x;
   endfunction

   initial begin
      logic [VW-1:0] va, wa;
      void'($urandom(32'h5EED_1234));
      va = rnd_vec();
      wa = rnd_vec();
      src_v_i = va;
      width_sel_i = 2'b11;
      repeat (3) @(negedge clk_i);
      // R8 reset state while reset is held
      check_vec("R8", res_o, '0);
      check_bit("R8", err_o, 1'b0);
      rst_ni = 1'b1;

      // R2/R3: W=16 pattern 10 11 01 10, select 0011
      apply("R3", va, wa, 2'b01, 8'b10_11_01_10, 4'b0011);
      check_vec("R2", {{(VW-64){1'b0}}, res_o[63:0]},
                {{(VW-64){1'b0}}, wa[47:16], va[63:32]});
      // R9: copy at the largest legal width
      apply("R9", va, wa, 2'b10, 8'h1B, 4'h0);
      check_vec("R9", res_o, va);
      apply("R9", va, wa, 2'b10, 8'h1B, 4'hF);
      check_vec("R9", res_o, wa);
      // R4: 8-bit sub-words, four pattern repetitions
      apply("R4", va, wa, 2'b00, 8'b11_00_10_01, 4'b1010);
      apply("R4", va, wa, 2'b00, 8'hFF, 4'b0000);
      // R1: 32-bit sub-words with all-zero index
      apply("R1", va, wa, 2'b10, 8'h00, 4'b0101);
      // R5: illegal width right after a legal result, result must hold
      apply("R5", rnd_vec(), rnd_vec(), 2'b11, 8'h1B, 4'h0);
      apply("R5", rnd_vec(), rnd_vec(), 2'b11, 8'hE4, 4'hF);
      // R6: legal again
      apply("R6", va, wa, 2'b01, 8'h39, 4'b1100);

      // random mix including illegal codes
      for (int t = 0; t < 400; t++) begin
         apply("R4", rnd_vec(), rnd_vec(), 2'($urandom_range(3)),
               8'($urandom()), 4'($urandom()));
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule